// File: doc/BRIEF.md
# Legacy Address Decoder with SMI Trap

This block sits beside a system bus and sorts each request it sees. A memory request is sent to system memory, sent to the graphics path, or flagged as lying beyond the configured memory ceiling. An I/O request to one of the legacy video port groups can instead raise a one-cycle system-management interrupt pulse. Before any decision is made, address bit 20 can be cleared to emulate the old 1 MB wrap. Requests made in system-management mode are exempt from that clearing.

Two 32-bit registers hold the configuration, and software reaches them through a plain write/read port. The ceiling register sets the top of system memory in 128 KB steps and comes out of reset at the 1 GB mark. The legacy-window register holds several controls: graphics steering for the two 32 KB monochrome and colour text windows at B0000h and B8000h, a 4-bit control nibble for each of those windows, the bit-20 mask enable, an enable for slave access to internal registers, and one trap enable per video port group. Every classification is registered and appears one cycle after the request.

Top module: `sysbus_region_decoder`

## Requirements
- R1: After reset, reading offset 00h returns 3FFFFFFFh, reading offset 04h returns 00000000h, and reg_slave_en, cls_valid, every class flag and smi_pulse are low.
- R2: Offset 00h (ceiling) stores write bits 29:17. A read returns those bits with bits 31:30 as zero and bits 16:0 as ones, whatever was written. The memory ceiling is the read value.
- R3: Offset 04h (legacy-window map) stores write bits 28:24 and 22:13. A read returns bits 31:29, bit 23 and bits 12:0 as zero.
- R4: A write with reg_we high lands on the clock edge that samples it. reg_rdata shows the register chosen by reg_sel one edge after reg_sel is presented. Any offset other than 00h and 04h reads as zero.
- R5: Each memory request raises exactly one of cls_sysmem, cls_gfx and cls_above_top. cls_above_top is raised when the effective address is greater than the ceiling and the request is not steered to graphics. Otherwise cls_sysmem is raised.
- R6: With map bit 28 set, memory requests to B8000h–BFFFFh raise cls_gfx. With map bit 20 set, memory requests to B0000h–B7FFFh raise cls_gfx. An address outside the enabled window is not steered.
- R7: Graphics steering wins over the ceiling test. A steered request raises cls_gfx even when the ceiling is below the window.
- R8: With map bit 21 set, the effective address (cls_addr) has bit 20 cleared for every request not made with req_smm. A request with req_smm high keeps its address unchanged. Classification uses the effective address.
- R9: Each I/O request raises no memory class flag. Its port number is req_addr[15:0]. The request pulses smi_pulse for one cycle when the port is in 3D0h–3DFh with map bit 15 set, in 3C0h–3CFh with bit 14 set, or in 3B0h–3BFh with bit 13 set. A memory request never pulses smi_pulse.
- R10: For a memory request in the B8000h window, cls_win_ctrl shows map bits 27:24. For the B0000h window it shows bits 19:16. For any other request it is zero. This holds whether or not steering is enabled.
- R11: reg_slave_en follows map bit 22 from the edge that writes it.
- R12: cls_valid and the classification outputs update on the edge that samples req_valid. In a cycle after an edge with no request, cls_valid, the class flags and smi_pulse are all low. Back-to-back trapped requests give back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | REG_AW | Register byte offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_sel |
| reg_slave_en | output | 1 | Slave access to internal registers enabled |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address (port number in bits 15:0 for I/O) |
| req_is_io | input | 1 | High for I/O, low for memory |
| req_smm | input | 1 | Request made in system-management mode |
| cls_valid | output | 1 | Classification valid |
| cls_sysmem | output | 1 | Memory request goes to system memory |
| cls_gfx | output | 1 | Memory request steered to graphics |
| cls_above_top | output | 1 | Memory request above the ceiling |
| cls_win_ctrl | output | 4 | Control nibble of the legacy window hit |
| cls_addr | output | ADDR_W | Effective address after the bit-20 mask |
| smi_pulse | output | 1 | One-cycle system-management interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit address, ceiling bits 29:17 and a 128 KB step. With these, both the full 1 GB reset ceiling and a ceiling lowered to 1 MB or 128 KB can be reached. A low ceiling is what lets the precedence of graphics steering over the ceiling test show up in the B0000h and B8000h windows. With a 32-bit address, bit 20 can alias an address above 1 MB onto a graphics window, which shows that classification uses the masked address.

// File: rtl/srd_pkg.sv
package srd_pkg;

  localparam int REG_DW     = 32;
  localparam int OFS_CEIL   = 'h00;
  localparam int OFS_MAP    = 'h04;

  // Legacy-window map layout (software-visible positions)
  localparam int MB_GFX_B8  = 28;
  localparam int MB_CTL_B8  = 24;
  localparam int MB_SLAVE   = 22;
  localparam int MB_A20     = 21;
  localparam int MB_GFX_B0  = 20;
  localparam int MB_CTL_B0  = 16;
  localparam int MB_TRAP0   = 13;
  localparam int NUM_TRAPS  = 3;
  localparam logic [REG_DW-1:0] MAP_RW_MASK = 32'h1F7F_E000;

  // Legacy windows: 32 KB each, B0000h and B8000h
  localparam int WIN_LG     = 15;
  localparam int WIN_B0_IDX = 'h16;
  localparam int NUM_WIN    = 2;

  // I/O trap groups: 16 ports each, starting at 3B0h
  localparam logic [11:0] TRAP_FIRST = 12'h03B;
  localparam int A20_BIT    = 20;
  localparam int PORT_W     = 16;

  typedef struct packed {
    logic                 gfx_b8;
    logic [3:0]           ctl_b8;
    logic                 slave_en;
    logic                 a20_mask;
    logic                 gfx_b0;
    logic [3:0]           ctl_b0;
    logic [NUM_TRAPS-1:0] trap_en;
  } lwmap_t;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_SYSMEM = 2'd1,
    CLS_GFX    = 2'd2,
    CLS_ABOVE  = 2'd3
  } mem_cls_e;

endpackage

// File: rtl/srd_regs.sv
module srd_regs
  import srd_pkg::*;
#(
  parameter int REG_AW  = 8,
  parameter int CEIL_HI = 29,
  parameter int GRAN_LG = 17,
  localparam int CEIL_W = CEIL_HI - GRAN_LG + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_sel,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic [CEIL_W-1:0] ceil_field,
  output lwmap_t            map
);

  logic              wr_ceil, wr_map;
  logic [REG_DW-1:0] ceil_word, map_word, rd_next;

  assign wr_ceil = reg_we && (reg_sel == REG_AW'(OFS_CEIL));
  assign wr_map  = reg_we && (reg_sel == REG_AW'(OFS_MAP));

  always_ff @(posedge clk) begin
    if (rst) begin
      ceil_field <= '1;
      map        <= '0;
    end else begin
      if (wr_ceil) ceil_field <= reg_wdata[CEIL_HI:GRAN_LG];
      if (wr_map) begin
        map.gfx_b8   <= reg_wdata[MB_GFX_B8];
        map.ctl_b8   <= reg_wdata[MB_CTL_B8 +: 4];
        map.slave_en <= reg_wdata[MB_SLAVE];
        map.a20_mask <= reg_wdata[MB_A20];
        map.gfx_b0   <= reg_wdata[MB_GFX_B0];
        map.ctl_b0   <= reg_wdata[MB_CTL_B0 +: 4];
        map.trap_en  <= reg_wdata[MB_TRAP0 +: NUM_TRAPS];
      end
    end
  end

  always_comb begin
    ceil_word                     = '0;
    ceil_word[GRAN_LG-1:0]        = '1;
    ceil_word[CEIL_HI:GRAN_LG]    = ceil_field;

    map_word                            = '0;
    map_word[MB_GFX_B8]                 = map.gfx_b8;
    map_word[MB_CTL_B8 +: 4]            = map.ctl_b8;
    map_word[MB_SLAVE]                  = map.slave_en;
    map_word[MB_A20]                    = map.a20_mask;
    map_word[MB_GFX_B0]                 = map.gfx_b0;
    map_word[MB_CTL_B0 +: 4]            = map.ctl_b0;
    map_word[MB_TRAP0 +: NUM_TRAPS]     = map.trap_en;

    if (reg_sel == REG_AW'(OFS_CEIL))     rd_next = ceil_word;
    else if (reg_sel == REG_AW'(OFS_MAP)) rd_next = map_word;
    else                                  rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  // Reserved write bits are dropped on purpose
  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[REG_DW-1:CEIL_HI+1], reg_wdata[MB_TRAP0-1:0]};

endmodule

// File: rtl/srd_mem_route.sv
module srd_mem_route
  import srd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CEIL_HI = 29,
  parameter int GRAN_LG = 17,
  localparam int CEIL_W = CEIL_HI - GRAN_LG + 1,
  localparam int WA_W   = ADDR_W - WIN_LG
) (
  input  logic [WA_W-1:0]         win_addr,
  input  logic [CEIL_W-1:0]       ceil_field,
  input  logic [NUM_WIN-1:0]      gfx_en,
  input  logic [NUM_WIN-1:0][3:0] win_ctl,
  output mem_cls_e                cls,
  output logic [3:0]              win_ctrl
);

  localparam int BLK_W = ADDR_W - GRAN_LG;

  logic [BLK_W-1:0]   blk, top_ext;
  logic               above;
  logic [NUM_WIN-1:0] hit, steer;

  assign blk = win_addr[WA_W-1:GRAN_LG-WIN_LG];

  always_comb begin
    top_ext             = '0;
    top_ext[CEIL_W-1:0] = ceil_field;
  end

  assign above = blk > top_ext;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign hit[w]   = (win_addr == WA_W'(WIN_B0_IDX + w));
    assign steer[w] = hit[w] && gfx_en[w];
  end

  always_comb begin
    if (|steer)     cls = CLS_GFX;
    else if (above) cls = CLS_ABOVE;
    else            cls = CLS_SYSMEM;

    win_ctrl = 4'h0;
    for (int w = 0; w < NUM_WIN; w++)
      if (hit[w]) win_ctrl = win_ctl[w];
  end

endmodule

// File: rtl/srd_io_trap.sv
module srd_io_trap
  import srd_pkg::*;
#(
  parameter int NTRAP = NUM_TRAPS
) (
  input  logic [11:0]      port_blk,
  input  logic [NTRAP-1:0] trap_en,
  output logic             trap
);

  logic [NTRAP-1:0] hit;

  for (genvar g = 0; g < NTRAP; g++) begin : g_grp
    assign hit[g] = trap_en[g] && (port_blk == TRAP_FIRST + 12'(g));
  end

  assign trap = |hit;

endmodule

// File: rtl/sysbus_region_decoder.sv
module sysbus_region_decoder
  import srd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int REG_AW  = 8,
  parameter int CEIL_HI = 29,
  parameter int GRAN_LG = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_slave_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_io,
  input  logic              req_smm,
  output logic              cls_valid,
  output logic              cls_sysmem,
  output logic              cls_gfx,
  output logic              cls_above_top,
  output logic [3:0]        cls_win_ctrl,
  output logic [ADDR_W-1:0] cls_addr,
  output logic              smi_pulse
);

  localparam int CEIL_W = CEIL_HI - GRAN_LG + 1;

  logic [CEIL_W-1:0] ceil_field;
  lwmap_t            map;
  logic [ADDR_W-1:0] eff_addr;
  mem_cls_e          mcls;
  logic [3:0]        wctrl;
  logic              io_trap;
  logic              is_mem;

  srd_regs #(.REG_AW(REG_AW), .CEIL_HI(CEIL_HI), .GRAN_LG(GRAN_LG)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ceil_field (ceil_field),
    .map        (map)
  );

  // Bit-20 wrap emulation, bypassed in system-management mode
  always_comb begin
    eff_addr = req_addr;
    if (map.a20_mask && !req_smm) eff_addr[A20_BIT] = 1'b0;
  end

  srd_mem_route #(.ADDR_W(ADDR_W), .CEIL_HI(CEIL_HI), .GRAN_LG(GRAN_LG)) u_route (
    .win_addr   (eff_addr[ADDR_W-1:WIN_LG]),
    .ceil_field (ceil_field),
    .gfx_en     ({map.gfx_b8, map.gfx_b0}),
    .win_ctl    ({map.ctl_b8, map.ctl_b0}),
    .cls        (mcls),
    .win_ctrl   (wctrl)
  );

  srd_io_trap #(.NTRAP(NUM_TRAPS)) u_trap (
    .port_blk (eff_addr[PORT_W-1:4]),
    .trap_en  (map.trap_en),
    .trap     (io_trap)
  );

  assign is_mem       = req_valid && !req_is_io;
  assign reg_slave_en = map.slave_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_valid     <= 1'b0;
      cls_sysmem    <= 1'b0;
      cls_gfx       <= 1'b0;
      cls_above_top <= 1'b0;
      cls_win_ctrl  <= '0;
      cls_addr      <= '0;
      smi_pulse     <= 1'b0;
    end else begin
      cls_valid     <= req_valid;
      cls_sysmem    <= is_mem && (mcls == CLS_SYSMEM);
      cls_gfx       <= is_mem && (mcls == CLS_GFX);
      cls_above_top <= is_mem && (mcls == CLS_ABOVE);
      cls_win_ctrl  <= is_mem ? wctrl : 4'h0;
      smi_pulse     <= req_valid && req_is_io && io_trap;
      if (req_valid) cls_addr <= eff_addr;
    end
  end

endmodule

// File: rtl/srd_checker.sv
module srd_checker
  import srd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int REG_AW  = 8,
  parameter int CEIL_HI = 29,
  parameter int GRAN_LG = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_sel,
  input logic              wr_slave_bit,
  input logic [31:0]       reg_rdata,
  input logic              reg_slave_en,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_is_io,
  input logic              req_smm,
  input logic              cls_valid,
  input logic              cls_sysmem,
  input logic              cls_gfx,
  input logic              cls_above_top,
  input logic [ADDR_W-1:0] cls_addr,
  input logic              smi_pulse
);

  p_ceil_read_r2: assert property (@(posedge clk) disable iff (rst)
    reg_sel == REG_AW'(OFS_CEIL) |=>
      (reg_rdata[31:CEIL_HI+1] == '0) && (&reg_rdata[GRAN_LG-1:0]));

  p_map_resv_r3: assert property (@(posedge clk) disable iff (rst)
    reg_sel == REG_AW'(OFS_MAP) |=> (reg_rdata & ~MAP_RW_MASK) == '0);

  p_class_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cls_sysmem, cls_gfx, cls_above_top}));

  p_mem_one_class_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_is_io |=> $countones({cls_sysmem, cls_gfx, cls_above_top}) == 1);

  p_smm_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_smm |=> cls_addr == $past(req_addr));

  p_low_addr_kept_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> cls_addr[A20_BIT-1:0] == $past(req_addr[A20_BIT-1:0]));

  p_io_no_mem_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_is_io |=> !cls_sysmem && !cls_gfx && !cls_above_top);

  p_smi_only_io_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_is_io |=> !smi_pulse);

  p_smi_single_r9: assert property (@(posedge clk) disable iff (rst)
    smi_pulse && !req_valid |=> !smi_pulse);

  p_slave_en_r11: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_sel == REG_AW'(OFS_MAP) |=> reg_slave_en == $past(wr_slave_bit));

  p_valid_tracks_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> cls_valid);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !cls_valid && !cls_sysmem && !cls_gfx && !cls_above_top && !smi_pulse);

endmodule

bind sysbus_region_decoder srd_checker #(
  .ADDR_W(ADDR_W), .REG_AW(REG_AW), .CEIL_HI(CEIL_HI), .GRAN_LG(GRAN_LG)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_we        (reg_we),
  .reg_sel       (reg_sel),
  .wr_slave_bit  (reg_wdata[22]),
  .reg_rdata     (reg_rdata),
  .reg_slave_en  (reg_slave_en),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .req_is_io     (req_is_io),
  .req_smm       (req_smm),
  .cls_valid     (cls_valid),
  .cls_sysmem    (cls_sysmem),
  .cls_gfx       (cls_gfx),
  .cls_above_top (cls_above_top),
  .cls_addr      (cls_addr),
  .smi_pulse     (smi_pulse)
);

// File: tb/sysbus_region_decoder_tb.sv
`timescale 1ns/1ps
module sysbus_region_decoder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_sel = 8'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_slave_en;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_is_io = 1'b0;
  logic        req_smm = 1'b0;
  logic        cls_valid, cls_sysmem, cls_gfx, cls_above_top, smi_pulse;
  logic [3:0]  cls_win_ctrl;
  logic [31:0] cls_addr;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  localparam logic [2:0] C_SYS = 3'b100, C_GFX = 3'b010, C_ABV = 3'b001, C_NONE = 3'b000;

  always #2 clk = ~clk;

  sysbus_region_decoder u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_slave_en(reg_slave_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_is_io(req_is_io), .req_smm(req_smm), .cls_valid(cls_valid),
    .cls_sysmem(cls_sysmem), .cls_gfx(cls_gfx), .cls_above_top(cls_above_top),
    .cls_win_ctrl(cls_win_ctrl), .cls_addr(cls_addr), .smi_pulse(smi_pulse)
  );

  function automatic logic [2:0] cls3();
    return {cls_sysmem, cls_gfx, cls_above_top};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // Present one request; on return the outputs hold its classification
  task automatic req(input logic [31:0] a, input logic io, input logic smm);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_is_io = io; req_smm = smm;
    @(negedge clk);
    req_valid = 1'b0; req_is_io = 1'b0; req_smm = 1'b0;
  endtask

  task automatic expect_cls(input logic [31:0] a, input logic [2:0] exp, input string tag);
    req(a, 1'b0, 1'b0);
    chk(cls_valid && cls3() == exp, tag, {28'h0, cls_valid, cls3()}, {28'h0, 1'b1, exp});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(!cls_valid && cls3() == C_NONE && !smi_pulse && !reg_slave_en, "R1 outputs after reset",
        {27'h0, cls_valid, cls3(), smi_pulse}, 32'h0);
    rd(8'h00, d); chk(d == 32'h3FFF_FFFF, "R1 ceiling default", d, 32'h3FFF_FFFF);
    rd(8'h04, d); chk(d == 32'h0, "R1 map default", d, 32'h0);
  endtask

  task automatic t_ceil_reg;
    logic [31:0] d;
    logic [31:0] pats [3] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0123_4567};
    foreach (pats[i]) begin
      wr(8'h00, pats[i]);
      rd(8'h00, d);
      chk(d == ((pats[i] & 32'h3FFE_0000) | 32'h0001_FFFF), "R2 ceiling readback",
          d, (pats[i] & 32'h3FFE_0000) | 32'h0001_FFFF);
    end
    wr(8'h00, 32'h3FFF_FFFF);
  endtask

  task automatic t_map_reg;
    logic [31:0] d;
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d);
    chk(d == 32'h1F7F_E000, "R3 map reserved bits", d, 32'h1F7F_E000);
    wr(8'h04, 32'h0000_0000); rd(8'h04, d);
    chk(d == 32'h0, "R3 map cleared", d, 32'h0);
  endtask

  task automatic t_reg_timing;
    logic [31:0] d;
    // R4: write then present sel on the next cycle; value visible one edge later
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, d); chk(d == 32'h0001_FFFF, "R4 write visible next read", d, 32'h0001_FFFF);
    rd(8'h08, d); chk(d == 32'h0, "R4 unmapped offset", d, 32'h0);
    rd(8'hFC, d); chk(d == 32'h0, "R4 unmapped offset high", d, 32'h0);
    wr(8'h00, 32'h3FFF_FFFF);
  endtask

  task automatic t_mem_route;
    expect_cls(32'h3FFF_FFFF, C_SYS, "R5 top of 1GB is system memory");
    expect_cls(32'h4000_0000, C_ABV, "R5 1GB is above ceiling");
    expect_cls(32'h0000_0000, C_SYS, "R5 zero is system memory");
    wr(8'h00, 32'h000E_0000);   // ceiling 000FFFFFh
    expect_cls(32'h000F_FFFF, C_SYS, "R5 at 1MB ceiling");
    expect_cls(32'h0010_0000, C_ABV, "R5 past 1MB ceiling");
    wr(8'h00, 32'h3FFF_FFFF);
  endtask

  task automatic t_gfx;
    wr(8'h04, 32'h1000_0000);   // bit 28
    expect_cls(32'h000B_8000, C_GFX, "R6 B8 window start");
    expect_cls(32'h000B_FFFF, C_GFX, "R6 B8 window end");
    expect_cls(32'h000B_7FFF, C_SYS, "R6 below B8 window");
    expect_cls(32'h000C_0000, C_SYS, "R6 above B8 window");
    wr(8'h04, 32'h0010_0000);   // bit 20
    expect_cls(32'h000B_0000, C_GFX, "R6 B0 window");
    expect_cls(32'h000B_8000, C_SYS, "R6 B8 not enabled");
    wr(8'h04, 32'h0);
  endtask

  task automatic t_precedence;
    wr(8'h00, 32'h0000_0000);   // ceiling 1FFFFh
    wr(8'h04, 32'h1010_0000);
    expect_cls(32'h000B_4000, C_GFX, "R7 B0 steer over ceiling");
    expect_cls(32'h000B_C000, C_GFX, "R7 B8 steer over ceiling");
    expect_cls(32'h000A_0000, C_ABV, "R7 unsteered above ceiling");
    wr(8'h00, 32'h3FFF_FFFF);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_a20;
    wr(8'h04, 32'h0020_0000);   // bit 21
    req(32'h0010_0000, 1'b0, 1'b0);
    chk(cls_addr == 32'h0, "R8 bit20 cleared", cls_addr, 32'h0);
    req(32'h0010_0000, 1'b0, 1'b1);
    chk(cls_addr == 32'h0010_0000, "R8 SMM bypass", cls_addr, 32'h0010_0000);
    req(32'h0030_0005, 1'b0, 1'b0);
    chk(cls_addr == 32'h0020_0005, "R8 only bit20 cleared", cls_addr, 32'h0020_0005);
    wr(8'h04, 32'h1020_0000);   // mask + B8 steering
    expect_cls(32'h001B_8000, C_GFX, "R8 masked address steered");
    chk(cls_addr == 32'h000B_8000, "R8 masked address value", cls_addr, 32'h000B_8000);
    wr(8'h04, 32'h0);
    req(32'h0010_0000, 1'b0, 1'b0);
    chk(cls_addr == 32'h0010_0000, "R8 mask off", cls_addr, 32'h0010_0000);
  endtask

  task automatic t_io_trap;
    wr(8'h04, 32'h0000_8000);   // bit 15: 3Dx
    req(32'h0000_03D4, 1'b1, 1'b0);
    chk(smi_pulse && cls3() == C_NONE, "R9 3Dx trap", {28'h0, smi_pulse, cls3()}, 32'h8);
    @(negedge clk);
    chk(!smi_pulse, "R9 pulse one cycle", {31'h0, smi_pulse}, 32'h0);
    req(32'h0000_03C4, 1'b1, 1'b0);
    chk(!smi_pulse, "R9 3Cx not enabled", {31'h0, smi_pulse}, 32'h0);
    wr(8'h04, 32'h0000_4000);   // bit 14: 3Cx
    req(32'h0000_03CF, 1'b1, 1'b0);
    chk(smi_pulse, "R9 3Cx trap", {31'h0, smi_pulse}, 32'h1);
    wr(8'h04, 32'h0000_2000);   // bit 13: 3Bx
    req(32'h0000_03B0, 1'b1, 1'b0);
    chk(smi_pulse, "R9 3Bx trap low", {31'h0, smi_pulse}, 32'h1);
    req(32'h0000_03BF, 1'b1, 1'b0);
    chk(smi_pulse, "R9 3Bx trap high", {31'h0, smi_pulse}, 32'h1);
    req(32'h0000_03AF, 1'b1, 1'b0);
    chk(!smi_pulse, "R9 3AFh outside", {31'h0, smi_pulse}, 32'h0);
    wr(8'h04, 32'h0000_E000);
    req(32'h0000_03D4, 1'b0, 1'b0);
    chk(!smi_pulse && cls3() == C_SYS, "R9 memory access no trap", {28'h0, smi_pulse, cls3()}, 32'h4);
    req(32'h0000_03E0, 1'b1, 1'b0);
    chk(!smi_pulse, "R9 3E0h outside", {31'h0, smi_pulse}, 32'h0);
  endtask

  task automatic t_winctrl;
    wr(8'h04, 32'h0A05_0000);
    req(32'h000B_8010, 1'b0, 1'b0);
    chk(cls_win_ctrl == 4'hA, "R10 B8 nibble", {28'h0, cls_win_ctrl}, 32'hA);
    req(32'h000B_0010, 1'b0, 1'b0);
    chk(cls_win_ctrl == 4'h5, "R10 B0 nibble", {28'h0, cls_win_ctrl}, 32'h5);
    req(32'h000C_0000, 1'b0, 1'b0);
    chk(cls_win_ctrl == 4'h0, "R10 outside windows", {28'h0, cls_win_ctrl}, 32'h0);
    req(32'h000B_8010, 1'b1, 1'b0);
    chk(cls_win_ctrl == 4'h0, "R10 I/O request", {28'h0, cls_win_ctrl}, 32'h0);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_slave;
    wr(8'h04, 32'h0040_0000);
    chk(reg_slave_en, "R11 slave enable set", {31'h0, reg_slave_en}, 32'h1);
    wr(8'h04, 32'h0);
    chk(!reg_slave_en, "R11 slave enable clear", {31'h0, reg_slave_en}, 32'h0);
  endtask

  task automatic t_timing;
    wr(8'h04, 32'h0000_8000);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h3D0; req_is_io = 1'b1;
    @(negedge clk);
    chk(cls_valid && smi_pulse, "R12 first back-to-back", {30'h0, cls_valid, smi_pulse}, 32'h3);
    req_addr = 32'h3DF;
    @(negedge clk);
    req_valid = 1'b0; req_is_io = 1'b0;
    chk(cls_valid && smi_pulse, "R12 second back-to-back", {30'h0, cls_valid, smi_pulse}, 32'h3);
    @(negedge clk);
    chk(!cls_valid && !smi_pulse && cls3() == C_NONE, "R12 idle quiet",
        {27'h0, cls_valid, cls3(), smi_pulse}, 32'h0);
    wr(8'h04, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ceil_reg();
    t_map_reg();
    t_reg_timing();
    t_mem_route();
    t_gfx();
    t_precedence();
    t_a20();
    t_io_trap();
    t_winctrl();
    t_slave();
    t_timing();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule